// File: doc/BRIEF.md
# PCI Configuration Access Sequencer

The sequencer sits between a host-side request port and a host-to-PCI bridge. It takes one configuration read or write at a time. Each request carries a packed bus/device/function tag, a register offset and, for writes, a data word. The block decides whether the target can be reached and forms the 32-bit configuration address. It then steps the bridge through the fixed access sequence. First it loads the window map with the upper address bits and a configuration-type code. Next it clears any stale abort status by writing ones. Then it performs the access through the configuration window. After a read it checks for aborts; after a write it waits until the posted-write FIFO has drained.

Two kinds of access are built. A bus-zero access sets a single device-select bit at position device plus a static select base. A bus-nonzero access passes the bus number through to the address and asserts the address-low enable on the map port. The bus-nonzero path is only open when the silicon revision input is high enough. The result comes back as a one-cycle done pulse carrying read data and an error flag. A read that failed, whether it was rejected or aborted, returns all-ones.

Top module: `pci_cfg_seq`

## Requirements
- R1: While reset is held, and at the first clock after it, req_ready_o is 1 and rsp_done_o, map_wr_o, stat_clr_o and win_req_o are all 0.
- R2: A request is taken when req_valid_i and req_ready_o are both 1. From then on req_ready_o stays 0 up to and including the cycle of rsp_done_o. rsp_done_o is high for exactly one cycle.
- R3: For bus 0 (tag bits 23:16 equal to 0) the address has bit (device + sel_base_i) set, the function (tag bits 10:8) in bits 10:8, and the offset in the low bits with offset bits 1:0 forced to 0. map_adr_o carries address bits 31:20, map_adlow_o is 0, map_type_o is 3'b101 and win_off_o carries address bits 19:0. The device number is tag bits 15:11.
- R4: A bus-0 request whose device + sel_base_i is greater than 31 is rejected.
- R5: A bus-nonzero request is accepted only when rev_i is 4 or more. The revision encoding is A=0, B0=1, B1=2, B2=3, C0=4. The address is then tag bits 23:8 placed at address bits 23:8, ORed with the aligned offset, and map_adlow_o is 1. With rev_i below 4 the request is rejected.
- R6: An accepted access first pulses map_wr_o. It then pulses stat_clr_o with stat_clr_mask_o = 2'b11 (bit 0 master abort, bit 1 target abort). Only after that does it raise win_req_o. Abort bits left over from before the request therefore do not affect the result.
- R7: If stat_abort_i is nonzero after a read's window access, the block pulses stat_clr_o with a mask equal to exactly the set bits. It then returns rsp_rdata_o = all-ones with rsp_err_o = 0.
- R8: A rejected request makes no map, clear or window strobe. A rejected read returns all-ones with rsp_err_o = 0. A rejected write returns rsp_err_o = 1.
- R9: A write puts req_wdata_i on win_wdata_o and the address on win_off_o with win_we_o = 1. rsp_done_o is not raised until the cycle after fifo_busy_i was seen low.
- R10: A read with no abort returns the win_rdata_i value captured with win_ack_i, with rsp_err_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, can accept |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_tag_i | input | 16 | Tag bits 23:8: bus 23:16, device 15:11, function 10:8 |
| req_offset_i | input | 8 | Register byte offset |
| req_wdata_i | input | 32 | Write data |
| sel_base_i | input | 5 | Static bit position of device 0 select |
| rev_i | input | 3 | Bridge silicon revision (ordered code) |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Read data, valid with done |
| rsp_err_o | output | 1 | Rejected write, valid with done |
| map_wr_o | output | 1 | Window map register write strobe |
| map_adr_o | output | 12 | Upper 12 address bits for the map |
| map_adlow_o | output | 1 | Address-low enable for the map |
| map_type_o | output | 3 | Access type code, configuration |
| stat_clr_o | output | 1 | Abort status write-one-to-clear strobe |
| stat_clr_mask_o | output | 2 | Bits to clear: 0 master, 1 target |
| stat_abort_i | input | 2 | Abort status bits from bridge |
| win_req_o | output | 1 | Window access request, held until ack |
| win_we_o | output | 1 | Window access is a write |
| win_off_o | output | 20 | Offset within configuration window |
| win_wdata_o | output | 32 | Window write data |
| win_rdata_i | input | 32 | Window read data, valid with ack |
| win_ack_i | input | 1 | Window access complete |
| fifo_busy_i | input | 1 | Posted-write FIFO not empty |

## Verification
The bench aims at the reach boundary. With device + base equal to 31 the access must reach the top address bit; one more must be refused. A decoder with an off-by-one compare would either drop bit 31 or wrap into a low select. It also checks the revision gate on both sides of C0. A wrong compare would either let a bus-nonzero access onto older silicon or shut out a legal one. Stale abort bits are planted before a clean read: a missing or late pre-access clear turns good data into all-ones. Single and double aborts check that the post-read clear names exactly the set bits. Writes with a slow FIFO catch a done pulse that fires before the drain ends, and rejected requests are watched for any stray downstream strobe.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 8;
  localparam int MAP_W  = 12;
  localparam int SEL_W  = 5;
  localparam int REV_W  = 3;
  localparam int TAG_HI = 23;
  localparam int TAG_LO = 8;

  localparam logic [2:0] MAP_CFG_CODE = 3'b101;
  localparam logic [1:0] ABORT_ALL    = 2'b11;

  typedef enum logic [REV_W-1:0] {
    REV_A  = 3'd0,
    REV_B0 = 3'd1,
    REV_B1 = 3'd2,
    REV_B2 = 3'd3,
    REV_C0 = 3'd4
  } rev_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MAP,
    ST_CLR,
    ST_ACC,
    ST_CHK,
    ST_DRAIN,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/pci_cfg_addr.sv
module pci_cfg_addr
  import pci_cfg_pkg::*;
#(
  parameter int ADDR_W = pci_cfg_pkg::ADDR_W,
  parameter int OFF_W  = pci_cfg_pkg::OFF_W,
  parameter int SEL_W  = pci_cfg_pkg::SEL_W,
  parameter int REV_W  = pci_cfg_pkg::REV_W
) (
  input  logic [TAG_HI:TAG_LO] tag_i,
  input  logic [OFF_W-1:0]     off_i,
  input  logic [SEL_W-1:0]     sel_base_i,
  input  logic [REV_W-1:0]     rev_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 adlow_o,
  output logic                 reject_o
);
  localparam logic [SEL_W:0] LAST_POS = (SEL_W+1)'(ADDR_W - 1);

  logic [7:0]       bus;
  logic [4:0]       dev;
  logic [2:0]       fn;
  logic [OFF_W-1:0] off_al;
  logic [SEL_W:0]   sel_pos;

  assign bus     = tag_i[23:16];
  assign dev     = tag_i[15:11];
  assign fn      = tag_i[10:8];
  assign off_al  = {off_i[OFF_W-1:2], 2'b00};
  assign sel_pos = (SEL_W+1)'(dev) + (SEL_W+1)'(sel_base_i);

  always_comb begin
    addr_o   = '0;
    adlow_o  = 1'b0;
    reject_o = 1'b0;
    if (bus == 8'd0) begin
      if (sel_pos > LAST_POS) begin
        reject_o = 1'b1;
      end else begin
        addr_o = (ADDR_W'(1) << sel_pos) | (ADDR_W'(fn) << 8) | ADDR_W'(off_al);
      end
    end else if (rev_i >= REV_C0) begin
      addr_o  = (ADDR_W'(tag_i) << TAG_LO) | ADDR_W'(off_al);
      adlow_o = 1'b1;
    end else begin
      reject_o = 1'b1;
    end
  end
endmodule

// File: rtl/pci_cfg_fsm.sv
module pci_cfg_fsm
  import pci_cfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       reject_i,
  input  logic       write_i,
  input  logic       win_ack_i,
  input  logic [1:0] abort_i,
  input  logic       fifo_busy_i,
  output logic       ready_o,
  output logic       map_wr_o,
  output logic       stat_clr_o,
  output logic [1:0] stat_clr_mask_o,
  output logic       win_req_o,
  output logic       cap_o,
  output logic       abort_hit_o,
  output logic       done_o
);
  seq_st_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = reject_i ? ST_DONE : ST_MAP;
      ST_MAP:   st_d = ST_CLR;
      ST_CLR:   st_d = ST_ACC;
      ST_ACC:   if (win_ack_i) st_d = write_i ? ST_DRAIN : ST_CHK;
      ST_CHK:   st_d = ST_DONE;
      ST_DRAIN: if (!fifo_busy_i) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ready_o         = (st_q == ST_IDLE);
    map_wr_o        = (st_q == ST_MAP);
    win_req_o       = (st_q == ST_ACC);
    done_o          = (st_q == ST_DONE);
    cap_o           = (st_q == ST_ACC) && win_ack_i && !write_i;
    abort_hit_o     = (st_q == ST_CHK) && (abort_i != 2'b00);
    stat_clr_o      = 1'b0;
    stat_clr_mask_o = 2'b00;
    if (st_q == ST_CLR) begin
      stat_clr_o      = 1'b1;
      stat_clr_mask_o = ABORT_ALL;
    end else if (abort_hit_o) begin
      stat_clr_o      = 1'b1;
      stat_clr_mask_o = abort_i;
    end
  end
endmodule

// File: rtl/pci_cfg_rsp.sv
module pci_cfg_rsp #(
  parameter int DATA_W = pci_cfg_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              reject_i,
  input  logic              write_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              abort_hit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else if (start_i) begin
      rdata_o <= reject_i ? '1 : '0;
      err_o   <= reject_i & write_i;
    end else begin
      if (cap_i)       rdata_o <= cap_data_i;
      if (abort_hit_i) rdata_o <= '1;
    end
  end
endmodule

// File: rtl/pci_cfg_seq.sv
module pci_cfg_seq
  import pci_cfg_pkg::*;
#(
  parameter int ADDR_W = pci_cfg_pkg::ADDR_W,
  parameter int DATA_W = pci_cfg_pkg::DATA_W,
  parameter int OFF_W  = pci_cfg_pkg::OFF_W,
  parameter int MAP_W  = pci_cfg_pkg::MAP_W,
  parameter int SEL_W  = pci_cfg_pkg::SEL_W,
  parameter int REV_W  = pci_cfg_pkg::REV_W,
  localparam int WOFF_W = ADDR_W - MAP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [TAG_HI:TAG_LO] req_tag_i,
  input  logic [OFF_W-1:0]     req_offset_i,
  input  logic [DATA_W-1:0]    req_wdata_i,
  input  logic [SEL_W-1:0]     sel_base_i,
  input  logic [REV_W-1:0]     rev_i,
  output logic                 rsp_done_o,
  output logic [DATA_W-1:0]    rsp_rdata_o,
  output logic                 rsp_err_o,
  output logic                 map_wr_o,
  output logic [MAP_W-1:0]     map_adr_o,
  output logic                 map_adlow_o,
  output logic [2:0]           map_type_o,
  output logic                 stat_clr_o,
  output logic [1:0]           stat_clr_mask_o,
  input  logic [1:0]           stat_abort_i,
  output logic                 win_req_o,
  output logic                 win_we_o,
  output logic [WOFF_W-1:0]    win_off_o,
  output logic [DATA_W-1:0]    win_wdata_o,
  input  logic [DATA_W-1:0]    win_rdata_i,
  input  logic                 win_ack_i,
  input  logic                 fifo_busy_i
);
  logic [ADDR_W-1:0] dec_addr, addr_q;
  logic              dec_adlow, dec_reject, adlow_q, write_q;
  logic [DATA_W-1:0] wdata_q;
  logic              start, cap, abort_hit;

  assign start = req_valid_i & req_ready_o;

  pci_cfg_addr #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEL_W(SEL_W), .REV_W(REV_W)
  ) u_addr (
    .tag_i      (req_tag_i),
    .off_i      (req_offset_i),
    .sel_base_i (sel_base_i),
    .rev_i      (rev_i),
    .addr_o     (dec_addr),
    .adlow_o    (dec_adlow),
    .reject_o   (dec_reject)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      adlow_q <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= dec_addr;
      adlow_q <= dec_adlow;
      write_q <= req_write_i;
      wdata_q <= req_wdata_i;
    end
  end

  pci_cfg_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start),
    .reject_i        (dec_reject),
    .write_i         (write_q),
    .win_ack_i       (win_ack_i),
    .abort_i         (stat_abort_i),
    .fifo_busy_i     (fifo_busy_i),
    .ready_o         (req_ready_o),
    .map_wr_o        (map_wr_o),
    .stat_clr_o      (stat_clr_o),
    .stat_clr_mask_o (stat_clr_mask_o),
    .win_req_o       (win_req_o),
    .cap_o           (cap),
    .abort_hit_o     (abort_hit),
    .done_o          (rsp_done_o)
  );

  pci_cfg_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .reject_i    (dec_reject),
    .write_i     (req_write_i),
    .cap_i       (cap),
    .cap_data_i  (win_rdata_i),
    .abort_hit_i (abort_hit),
    .rdata_o     (rsp_rdata_o),
    .err_o       (rsp_err_o)
  );

  assign map_adr_o   = addr_q[ADDR_W-1 -: MAP_W];
  assign map_adlow_o = adlow_q;
  assign map_type_o  = MAP_CFG_CODE;
  assign win_off_o   = addr_q[WOFF_W-1:0];
  assign win_we_o    = write_q;
  assign win_wdata_o = wdata_q;
endmodule

// File: rtl/pci_cfg_seq_chk.sv
module pci_cfg_seq_chk #(
  parameter int REV_W = pci_cfg_pkg::REV_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [REV_W-1:0] rev_i,
  input logic             rsp_done_o,
  input logic             map_wr_o,
  input logic             map_adlow_o,
  input logic             stat_clr_o,
  input logic [1:0]       stat_clr_mask_o,
  input logic             win_req_o,
  input logic             fifo_busy_i
);
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o); // R2
  AST_DONE_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> !req_ready_o); // R2
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({map_wr_o, stat_clr_o, win_req_o, rsp_done_o})); // R6
  AST_CLR_BEFORE_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_req_o) |-> $past(stat_clr_o) && $past(stat_clr_mask_o) == 2'b11); // R6
  AST_CLR_AFTER_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_clr_o |-> $past(map_wr_o) || $past(win_req_o)); // R6
  AST_DONE_AFTER_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |-> !$past(fifo_busy_i)); // R9
  AST_ADLOW_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_wr_o && map_adlow_o |-> rev_i >= 3'd4); // R5
endmodule

bind pci_cfg_seq pci_cfg_seq_chk #(.REV_W(REV_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .rev_i           (rev_i),
  .rsp_done_o      (rsp_done_o),
  .map_wr_o        (map_wr_o),
  .map_adlow_o     (map_adlow_o),
  .stat_clr_o      (stat_clr_o),
  .stat_clr_mask_o (stat_clr_mask_o),
  .win_req_o       (win_req_o),
  .fifo_busy_i     (fifo_busy_i)
);

// File: tb/pci_cfg_seq_bench.sv
module pci_cfg_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:8] req_tag = '0;
  logic [7:0]  req_off = '0;
  logic [31:0] req_wdata = '0;
  logic [4:0]  sel_base = 5'd11;
  logic [2:0]  rev = 3'd0;
  logic        ready, done, err, map_wr, map_adlow, stat_clr, win_req, win_we;
  logic [31:0] rdata, win_wdata;
  logic [11:0] map_adr;
  logic [2:0]  map_type;
  logic [1:0]  clr_mask;
  logic [19:0] win_off;
  logic [31:0] win_rdata = '0;
  logic        win_ack = 1'b0;
  logic [1:0]  abort_q = 2'b00;
  logic        fifo_busy;

  int errors = 0, checks = 0;
  int ack_delay = 0, ack_cnt = 0, drain_len = 0, fifo_cnt = 0;
  logic [1:0]  abort_inject = 2'b00, stale_val = 2'b00;
  logic [19:0] last_wr_off = '0;
  logic [31:0] last_wr_data = '0;

  // monitor record
  int n_map, n_clr, n_win, n_done, ph, ord_err, ready_err, fifo_at_done;
  logic [1:0]  pre_mask, post_mask;
  logic [11:0] m_adr; logic m_adlow; logic [2:0] m_type;
  logic [19:0] m_off; logic [31:0] m_rdata; logic m_err;
  bit busy_mon = 0;
  bit done_q = 0;

  always #10 clk = ~clk;

  pci_cfg_seq u_pci_cfg_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(ready), .req_write_i(req_write),
    .req_tag_i(req_tag), .req_offset_i(req_off), .req_wdata_i(req_wdata),
    .sel_base_i(sel_base), .rev_i(rev),
    .rsp_done_o(done), .rsp_rdata_o(rdata), .rsp_err_o(err),
    .map_wr_o(map_wr), .map_adr_o(map_adr), .map_adlow_o(map_adlow), .map_type_o(map_type),
    .stat_clr_o(stat_clr), .stat_clr_mask_o(clr_mask), .stat_abort_i(abort_q),
    .win_req_o(win_req), .win_we_o(win_we), .win_off_o(win_off), .win_wdata_o(win_wdata),
    .win_rdata_i(win_rdata), .win_ack_i(win_ack), .fifo_busy_i(fifo_busy)
  );

  assign fifo_busy = (fifo_cnt != 0);

  // downstream model: target, abort status (write one to clear), write FIFO
  always @(posedge clk) begin
    logic [1:0] ab;
    ab = abort_q | stale_val;
    if (stat_clr) ab = ab & ~clr_mask;
    if (fifo_cnt != 0) fifo_cnt <= fifo_cnt - 1;
    if (win_req && !win_ack) begin
      if (ack_cnt >= ack_delay) begin
        win_ack   <= 1'b1;
        ack_cnt   <= 0;
        win_rdata <= {12'hC0F, win_off};
        ab = ab | abort_inject;
        if (win_we) begin
          last_wr_off  <= win_off;
          last_wr_data <= win_wdata;
          fifo_cnt     <= drain_len;
        end
      end else ack_cnt <= ack_cnt + 1;
    end else win_ack <= 1'b0;
    abort_q <= ab;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_mon && ready && !done) ready_err++;
      if (map_wr) begin
        n_map++; m_adr = map_adr; m_adlow = map_adlow; m_type = map_type;
        if (ph != 0) ord_err++;
        ph = 1;
      end
      if (stat_clr) begin
        n_clr++;
        if (ph == 1) begin pre_mask = clr_mask; ph = 2; end
        else if (ph == 3) post_mask = clr_mask;
        else ord_err++;
      end
      if (win_req && ph == 2) begin n_win++; m_off = win_off; ph = 3; end
      else if (win_req && ph != 3) ord_err++;
      if (done) begin n_done++; m_rdata = rdata; m_err = err; fifo_at_done = fifo_cnt; end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit we, input logic [23:0] tag, input logic [7:0] off,
                     input logic [31:0] wd, input int dly, input int drain,
                     input logic [1:0] inj, input logic [1:0] stale);
    int bus, dev, fn, o;
    bit rej, adl;
    logic [31:0] a;
    bus = int'(tag[23:16]); dev = int'(tag[15:11]); fn = int'(tag[10:8]);
    o = int'(off) & 'hFC;
    rej = 0; adl = 0; a = '0;
    if (bus == 0) begin
      if (dev + int'(sel_base) > 31) rej = 1;
      else a = (32'h1 << (dev + int'(sel_base))) | 32'(fn << 8) | 32'(o);
    end else if (int'(rev) >= 4) begin
      a = {8'h00, tag[23:8], 8'h00} | 32'(o); adl = 1;
    end else rej = 1;

    ack_delay = dly; drain_len = drain; abort_inject = inj; stale_val = stale;
    @(negedge clk); stale_val = 2'b00;
    @(negedge clk);
    n_map = 0; n_clr = 0; n_win = 0; n_done = 0; ph = 0; ord_err = 0; ready_err = 0;
    pre_mask = 2'b00; post_mask = 2'b00;
    req_valid = 1; req_write = we; req_tag = tag[23:8]; req_off = off; req_wdata = wd;
    @(negedge clk);
    req_valid = 0; req_wdata = '0; req_tag = '0; req_off = '0; req_write = 0;
    busy_mon = 1;
    while (n_done == 0) @(negedge clk);
    busy_mon = 0;
    @(negedge clk);
    done_q = done;
    chk("R2", "busy ready", 32'(ready_err), 32'd0);
    chk("R2", "done one cycle, ready back", {30'd0, done_q, ready}, 32'd1);
    if (rej) begin
      chk(we ? "R8" : "R4/R5 R8", "no strobes", 32'(n_map + n_clr + n_win), 32'd0);
      if (we) chk("R8", "write reject err", {31'd0, m_err}, 32'd1);
      else begin
        chk("R8", "read reject data", m_rdata, 32'hFFFF_FFFF);
        chk("R8", "read reject err", {31'd0, m_err}, 32'd0);
      end
    end else begin
      chk("R6", "order", 32'(ord_err), 32'd0);
      chk("R6", "pre clear mask", {30'd0, pre_mask}, 32'd3);
      chk("R3", "map adr", {20'd0, m_adr}, {20'd0, a[31:20]});
      chk("R5", "map adlow", {31'd0, m_adlow}, {31'd0, adl});
      chk("R3", "map type", {29'd0, m_type}, 32'd5);
      chk("R3", "win off", {12'd0, m_off}, {12'd0, a[19:0]});
      if (we) begin
        chk("R9", "write data", last_wr_data, wd);
        chk("R9", "write off", {12'd0, last_wr_off}, {12'd0, a[19:0]});
        chk("R9", "fifo empty at done", 32'(fifo_at_done), 32'd0);
        chk("R9", "write err", {31'd0, m_err}, 32'd0);
      end else if (inj != 2'b00) begin
        chk("R7", "abort data", m_rdata, 32'hFFFF_FFFF);
        chk("R7", "post clear mask", {30'd0, post_mask}, {30'd0, inj});
        chk("R7", "status cleared", {30'd0, abort_q}, 32'd0);
        chk("R7", "abort err", {31'd0, m_err}, 32'd0);
      end else begin
        chk("R10", "read data", m_rdata, {12'hC0F, a[19:0]});
        chk("R10", "read err", {31'd0, m_err}, 32'd0);
        chk("R6", "clear count", 32'(n_clr), 32'd1);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "in reset", {27'd0, ready, done, map_wr, stat_clr, win_req}, 32'h10);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "after reset", {27'd0, ready, done, map_wr, stat_clr, win_req}, 32'h10);

    sel_base = 5'd11; rev = 3'd0;
    run(0, {8'd0, 5'd3, 3'd2, 8'h00}, 8'h10, 0, 1, 0, 2'b00, 2'b00);  // R3 R10
    run(0, {8'd0, 5'd7, 3'd5, 8'h00}, 8'h13, 0, 0, 0, 2'b00, 2'b00);  // R3 alignment
    run(0, {8'd0, 5'd20, 3'd1, 8'h00}, 8'h04, 0, 2, 0, 2'b00, 2'b00); // R4 edge, bit 31
    run(0, {8'd0, 5'd21, 3'd0, 8'h00}, 8'h00, 0, 0, 0, 2'b00, 2'b00); // R4 read reject
    run(1, {8'd0, 5'd21, 3'd0, 8'h00}, 8'h00, 32'h1234_5678, 0, 0, 2'b00, 2'b00); // R8
    run(0, {8'd5, 5'd2, 3'd1, 8'h00}, 8'h08, 0, 0, 0, 2'b00, 2'b00); // R5 rev A reject
    rev = 3'd3;
    run(0, {8'd5, 5'd2, 3'd1, 8'h00}, 8'h08, 0, 0, 0, 2'b00, 2'b00); // R5 rev B2 reject
    rev = 3'd4;
    run(0, {8'd5, 5'd2, 3'd1, 8'h00}, 8'h08, 0, 3, 0, 2'b00, 2'b00); // R5 type 1 read
    run(1, {8'd9, 5'd31, 3'd7, 8'h00}, 8'h3C, 32'hDEAD_BEEF, 1, 6, 2'b00, 2'b00); // R9 R5
    run(0, {8'd0, 5'd1, 3'd0, 8'h00}, 8'h00, 0, 0, 0, 2'b01, 2'b00); // R7 master
    run(0, {8'd0, 5'd1, 3'd0, 8'h00}, 8'h00, 0, 2, 0, 2'b10, 2'b00); // R7 target
    run(0, {8'd0, 5'd2, 3'd0, 8'h00}, 8'h20, 0, 0, 0, 2'b11, 2'b00); // R7 both
    run(0, {8'd0, 5'd4, 3'd3, 8'h00}, 8'h40, 0, 1, 0, 2'b00, 2'b11); // R6 stale
    run(1, {8'd0, 5'd6, 3'd2, 8'h00}, 8'h18, 32'h0BAD_F00D, 3, 0, 2'b00, 2'b00); // R9 no drain
    sel_base = 5'd0;
    run(0, {8'd0, 5'd0, 3'd7, 8'h00}, 8'hFF, 0, 0, 0, 2'b00, 2'b00); // R3 base 0
    run(0, {8'd0, 5'd31, 3'd0, 8'h00}, 8'h00, 0, 0, 0, 2'b00, 2'b00); // R4 dev 31 base 0
    sel_base = 5'd31;
    run(0, {8'd0, 5'd1, 3'd0, 8'h00}, 8'h00, 0, 0, 0, 2'b00, 2'b00); // R4 reject
    run(1, {8'd0, 5'd0, 3'd0, 8'h00}, 8'h00, 32'h5555_AAAA, 0, 2, 2'b00, 2'b00); // R9 bit 31

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule